// File: doc/BRIEF.md
# Variable-Rate Sample Request Pacer

This block decides, frame by frame, whether a codec link frame should carry a sample request for the front DAC pair and for the ADC pair. The link always runs at 48,000 frames per second. Each converter pair runs at a slower rate that software programs. To reach that rate, the block raises a request only in some frames, so that over time the number of requests equals the programmed rate exactly.

Software programs a rate by writing the rate in Hz as a plain 16-bit number to the register for that converter. The block stores only rates it supports. Any other value is replaced by the nearest supported rate, and later reads return that stored value. Every programmed rate drives a phase accumulator. On each frame strobe the accumulator adds the rate. When the sum reaches 48000, the request flag for that channel is raised for the coming frame, and 48000 is taken off the sum.

Each channel's flag is a two-state machine. `PH_QUIET` means no request in the current frame, and `PH_ASK` means a request in the current frame. A write to the channel's register moves the machine to `PH_QUIET` and zeroes its accumulator. If there is no write, a frame strobe moves it to `PH_ASK` when the sum reaches 48000, and to `PH_QUIET` otherwise. With no write and no strobe, the machine stays in its current state.

Top module: `vrate_req_pacer`

## Requirements
- R1: After reset both rate registers read 16'hBB80 (48000), and both request outputs are low.
- R2: Address 7'h2C holds the front DAC rate and address 7'h32 holds the ADC rate. One ADC rate and one `adc_req` serve both ADC channels. `reg_rdata` shows the register at the address presented one clock earlier. Any other address reads zero, and a write to it changes no stored rate.
- R3: Each supported rate is stored unchanged when written: 7200, 8000, 8228, 8400, 9000, 9600, 10285, 11025, 12000, 13714, 16000, 19200, 22050, 24000, 44100 and 48000.
- R4: Any other written value is stored as the closest supported rate. When two supported rates are equally close, the lower one is stored. Values above 48000 become 48000.
- R5: On each frame strobe a channel adds its rate to its accumulator. If the sum is 48000 or more, it raises its request and keeps the sum minus 48000. Otherwise it drops its request and keeps the sum.
- R6: At 48000 the request is high after every frame strobe.
- R7: At 24000, starting from a cleared accumulator, the request alternates low, high, low, high on successive frames.
- R8: A request output changes only on the clock edge of a frame strobe or of a write to that channel's register. Between those edges it holds for the whole frame.
- R9: A write to a rate register zeroes that channel's accumulator and drops its request. The other channel is not affected.
- R10: If a write and a frame strobe fall in the same cycle, the written channel is cleared as in R9 and skips that frame. The other channel advances normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_strobe | input | 1 | One-cycle pulse marking the start of a link frame |
| reg_addr | input | 7 | Register address for read and write |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 16 | Rate to write, in Hz |
| reg_rdata | output | 16 | Registered read data |
| dac_req | output | 1 | Front DAC pair sample request for the current frame |
| adc_req | output | 1 | ADC pair sample request for the current frame |

## Verification
A write is stored at the clock edge where `reg_we` is high. It becomes visible on `reg_rdata` one edge later, once the read address is presented. Request flags change at the edge that samples a strobe or a write, so each result is due one edge after its stimulus. The driver pushes one expected item for every stimulus cycle. The monitor pops and compares each item at the falling edge after the next rising edge, which is exactly one register stage downstream, and never reads a result in the same cycle as the write that produced it.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
    localparam int RATE_W    = 16;
    localparam int NUM_RATES = 16;
    localparam int NUM_CH    = 2;
    localparam int CH_DAC    = 0;
    localparam int CH_ADC    = 1;
    localparam logic [RATE_W-1:0] LINK_RATE = 16'd48000;

    // Supported rates, ascending; ascending order makes ties resolve low.
    function automatic logic [RATE_W-1:0] supported_rate(input int unsigned idx);
        logic [RATE_W-1:0] r;
        case (idx)
            0:       r = 16'd7200;
            1:       r = 16'd8000;
            2:       r = 16'd8228;
            3:       r = 16'd8400;
            4:       r = 16'd9000;
            5:       r = 16'd9600;
            6:       r = 16'd10285;
            7:       r = 16'd11025;
            8:       r = 16'd12000;
            9:       r = 16'd13714;
            10:      r = 16'd16000;
            11:      r = 16'd19200;
            12:      r = 16'd22050;
            13:      r = 16'd24000;
            14:      r = 16'd44100;
            default: r = LINK_RATE;
        endcase
        return r;
    endfunction

    function automatic logic is_supported(input logic [RATE_W-1:0] v);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (supported_rate(i) == v) hit = 1'b1;
        end
        return hit;
    endfunction
endpackage

// File: rtl/rate_snapper.sv
module rate_snapper
    import vrp_pkg::*;
(
    input  logic [RATE_W-1:0] raw_rate,
    output logic [RATE_W-1:0] legal_rate
);
    logic [RATE_W-1:0] best;
    logic [RATE_W-1:0] best_gap;
    logic [RATE_W-1:0] cand;
    logic [RATE_W-1:0] gap;

    always_comb begin
        best     = supported_rate(0);
        best_gap = (raw_rate > best) ? raw_rate - best : best - raw_rate;
        cand     = '0;
        gap      = '0;
        for (int i = 1; i < NUM_RATES; i++) begin
            cand = supported_rate(i);
            gap  = (raw_rate > cand) ? raw_rate - cand : cand - raw_rate;
            // strict compare keeps the lower candidate on an exact tie
            if (gap < best_gap) begin
                best     = cand;
                best_gap = gap;
            end
        end
        legal_rate = best;
    end
endmodule

// File: rtl/rate_regfile.sv
module rate_regfile
    import vrp_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter logic [NUM_CH*ADDR_W-1:0] CH_ADDRS = {7'h32, 7'h2C}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_we,
    input  logic [RATE_W-1:0]             reg_wdata,
    output logic [RATE_W-1:0]             reg_rdata,
    output logic [NUM_CH-1:0][RATE_W-1:0] ch_rate,
    output logic [NUM_CH-1:0]             ch_wr
);
    logic [RATE_W-1:0]             legal;
    logic [NUM_CH-1:0]             sel;
    logic [NUM_CH-1:0][RATE_W-1:0] rate_q;
    logic [RATE_W-1:0]             rd_mux;

    rate_snapper u_snap (
        .raw_rate   (reg_wdata),
        .legal_rate (legal)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
        assign sel[c]   = (reg_addr == CH_ADDRS[c*ADDR_W +: ADDR_W]);
        assign ch_wr[c] = reg_we && sel[c];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        rate_q[c] <= LINK_RATE;
            else if (ch_wr[c]) rate_q[c] <= legal;
        end

        assert_reg_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
            is_supported(rate_q[c]))
            else $error("stored rate not a supported value");
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel[c]) rd_mux = rate_q[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_rdata <= '0;
        else        reg_rdata <= rd_mux;
    end

    assign ch_rate = rate_q;

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |=> (reg_rdata == '0))
        else $error("unmapped read returned nonzero");
endmodule

// File: rtl/frame_pacer.sv
module frame_pacer
    import vrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic              req
);
    typedef enum logic {PH_QUIET, PH_ASK} phase_e;

    localparam logic [RATE_W:0] SUM_LIMIT = {1'b0, LINK_RATE};
    localparam logic [RATE_W-1:0] HALF_RATE = LINK_RATE >> 1;

    phase_e            state_q, state_d;
    logic [RATE_W-1:0] acc_q, acc_d;
    logic [RATE_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, rate};

    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        if (clear) begin
            state_d = PH_QUIET;
            acc_d   = '0;
        end else if (frame_strobe) begin
            if (sum >= SUM_LIMIT) begin
                state_d = PH_ASK;
                acc_d   = RATE_W'(sum - SUM_LIMIT);
            end else begin
                state_d = PH_QUIET;
                acc_d   = sum[RATE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_QUIET;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PH_QUIET: req = 1'b0;
            PH_ASK:   req = 1'b1;
            default:  req = 1'b0;
        endcase
    end

    assert_acc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < LINK_RATE)
        else $error("accumulator left its range");

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_strobe && !clear) |=> $stable(req))
        else $error("request changed between frames");

    assert_full_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !clear && rate == LINK_RATE) |=> req)
        else $error("full rate missed a request");

    assert_half_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !clear && rate == HALF_RATE && req) |=> !req)
        else $error("half rate did not alternate");

    assert_write_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!req && acc_q == '0))
        else $error("write did not clear the channel");

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && frame_strobe) |=> !req)
        else $error("strobe overrode a same-cycle write");
endmodule

// File: rtl/vrate_req_pacer.sv
module vrate_req_pacer
    import vrp_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter logic [ADDR_W-1:0] DAC_ADDR = 7'h2C,
    parameter logic [ADDR_W-1:0] ADC_ADDR = 7'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              dac_req,
    output logic              adc_req
);
    localparam logic [NUM_CH*ADDR_W-1:0] ADDR_MAP = {ADC_ADDR, DAC_ADDR};

    logic [NUM_CH-1:0][RATE_W-1:0] ch_rate;
    logic [NUM_CH-1:0]             ch_wr;
    logic [NUM_CH-1:0]             ch_req;

    rate_regfile #(
        .ADDR_W   (ADDR_W),
        .CH_ADDRS (ADDR_MAP)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ch_rate   (ch_rate),
        .ch_wr     (ch_wr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        frame_pacer u_pace (
            .clk          (clk),
            .rst_n        (rst_n),
            .frame_strobe (frame_strobe),
            .clear        (ch_wr[c]),
            .rate         (ch_rate[c]),
            .req          (ch_req[c])
        );
    end

    assign dac_req = ch_req[CH_DAC];
    assign adc_req = ch_req[CH_ADC];
endmodule

// File: tb/test_vrate_req_pacer.sv
module test_vrate_req_pacer;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] A_DAC = 7'h2C;
    localparam logic [6:0] A_ADC = 7'h32;
    localparam logic [15:0] RATES [16] = '{16'd7200, 16'd8000, 16'd8228, 16'd8400,
        16'd9000, 16'd9600, 16'd10285, 16'd11025, 16'd12000, 16'd13714, 16'd16000,
        16'd19200, 16'd22050, 16'd24000, 16'd44100, 16'd48000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_strobe = 1'b0;
    logic [6:0] reg_addr = '0;
    logic reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic dac_req, adc_req;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;
    logic drv_valid = 1'b0;
    logic due = 1'b0;

    // expected item: bit16 = read check, [15:0] data or {dac,adc} in [1:0]
    logic [16:0] exp_q[$];
    string tag_q[$];

    logic [15:0] m_rate [2];
    logic [16:0] m_acc [2];
    logic m_req [2];

    vrate_req_pacer i_vrate_req_pacer (
        .clk (clk), .rst_n (rst_n), .frame_strobe (frame_strobe),
        .reg_addr (reg_addr), .reg_we (reg_we), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .dac_req (dac_req), .adc_req (adc_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] snap_m(input logic [15:0] v);
        logic [15:0] best, bg, g;
        best = RATES[0];
        bg = (v > best) ? v - best : best - v;
        for (int i = 1; i < 16; i++) begin
            g = (v > RATES[i]) ? v - RATES[i] : RATES[i] - v;
            if (g < bg) begin best = RATES[i]; bg = g; end
        end
        return best;
    endfunction

    task automatic cyc(input logic [6:0] a, input logic we, input logic [15:0] d,
                       input logic fs, input logic rd, input string tag);
        logic [16:0] e;
        logic [1:0] wr_ch;
        @(negedge clk);
        reg_addr = a; reg_we = we; reg_wdata = d; frame_strobe = fs; drv_valid = 1'b1;
        e = '0;
        if (rd) e = {1'b1, (a == A_DAC) ? m_rate[0] : (a == A_ADC) ? m_rate[1] : 16'h0000};
        wr_ch = {we && a == A_ADC, we && a == A_DAC};
        for (int c = 0; c < 2; c++) begin
            if (wr_ch[c]) begin
                m_rate[c] = snap_m(d); m_acc[c] = 0; m_req[c] = 1'b0;
            end else if (fs) begin
                m_acc[c] = m_acc[c] + {1'b0, m_rate[c]};
                if (m_acc[c] >= 17'd48000) begin m_req[c] = 1'b1; m_acc[c] = m_acc[c] - 17'd48000; end
                else m_req[c] = 1'b0;
            end
        end
        if (!rd) e = {15'd0, m_req[0], m_req[1]};
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic frm(input string tag);  cyc(7'h00, 1'b0, 16'h0, 1'b1, 1'b0, tag); endtask
    task automatic idle(input string tag); cyc(7'h00, 1'b0, 16'h0, 1'b0, 1'b0, tag); endtask
    task automatic wr(input logic [6:0] a, input logic [15:0] d, input string tag);
        cyc(a, 1'b1, d, 1'b0, 1'b0, tag);
    endtask
    task automatic rd(input logic [6:0] a, input string tag);
        cyc(a, 1'b0, 16'h0, 1'b0, 1'b1, tag);
    endtask
    task automatic wr_rd(input logic [6:0] a, input logic [15:0] d, input string tag);
        wr(a, d, tag);
        rd(a, tag);
    endtask

    always @(posedge clk) due <= drv_valid;

    initial begin
        logic [16:0] e;
        string t;
        forever begin
            @(negedge clk);
            if (due && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (e[16]) begin
                    if (reg_rdata !== e[15:0]) begin
                        bad++;
                        $display("FAIL %s read actual=%h expected=%h", t, reg_rdata, e[15:0]);
                    end
                end else if ({dac_req, adc_req} !== e[1:0]) begin
                    bad++;
                    $display("FAIL %s flags actual=%b expected=%b", t, {dac_req, adc_req}, e[1:0]);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R5 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin m_rate[c] = 16'hBB80; m_acc[c] = 0; m_req[c] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_DAC, "R1"); rd(A_ADC, "R1"); idle("R1");
        // R6 full rate on both channels
        repeat (3) frm("R6");
        // R7 half rate on DAC, ADC stays full (R2 separate registers)
        wr_rd(A_DAC, 16'h5DC0, "R7");
        repeat (4) frm("R7");
        // R8 flags hold between strobes
        repeat (3) idle("R8");
        // R5 fractional pacing at 44100 on ADC, 8000 on DAC
        wr_rd(A_ADC, 16'hAC44, "R5");
        wr_rd(A_DAC, 16'h1F40, "R5");
        repeat (14) begin frm("R5"); idle("R8"); end
        // R9 write to ADC mid-run clears only ADC
        wr(A_ADC, 16'd22050, "R9");
        idle("R9");
        repeat (5) frm("R9");
        // R10 write and strobe in the same cycle
        cyc(A_DAC, 1'b1, 16'd16000, 1'b1, 1'b0, "R10");
        repeat (4) frm("R10");
        // R3 every supported value stored unchanged
        for (int i = 0; i < 16; i++) wr_rd(A_DAC, RATES[i], "R3");
        // R4 snapping, ties resolve low
        wr_rd(A_DAC, 16'd7600,  "R4");
        wr_rd(A_DAC, 16'd0,     "R4");
        wr_rd(A_DAC, 16'hFFFF,  "R4");
        wr_rd(A_ADC, 16'd30000, "R4");
        wr_rd(A_ADC, 16'd46050, "R4");
        wr_rd(A_ADC, 16'd46051, "R4");
        wr_rd(A_DAC, 16'd8229,  "R4");
        wr_rd(A_DAC, 16'd11000, "R4");
        // R2 unmapped address
        wr(7'h30, 16'h1234, "R2");
        rd(7'h30, "R2"); rd(A_DAC, "R2"); rd(A_ADC, "R2");
        wr(7'h2E, 16'd8000, "R2");
        rd(7'h2E, "R2"); rd(A_DAC, "R2");
        repeat (6) frm("R5");
        @(negedge clk);
        drv_valid = 1'b0; frame_strobe = 1'b0; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule